// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns the one-bit density stream from an external second-order delta-sigma modulator into 16-bit conversion words. It samples the stream on every modulator clock. Three cascaded accumulators run at that rate. Once per decimation period their final sum is taken into three cascaded difference stages, and these stages run only at the word rate. The combined response is the cube of a length-OSR moving sum. Each difference result is shifted according to the selected ratio and then clipped, so the full-scale code is the same for every ratio.

The decimation ratio is chosen at run time with a three-bit select, and a new select is applied at a word boundary. Each new word comes with a one-cycle strobe. A settled flag tells downstream logic which words are free of start-up transients. Those are the words from the third onward after a reset or after a ratio switch.

Top module: `sinc3_decimator`

## Requirements
- R1: An input of 1 counts as +1 and an input of 0 counts as 0. For a periodic input whose period divides the ratio and has a fraction `d` of ones, every settled word equals `d * 32768`. An all-zero input therefore gives 0.
- R2: A constant all-ones input gives the clipped full-scale word 32767 at every supported ratio.
- R3: Select codes 0, 1, 2, 3 and 4 choose ratios 16, 32, 64, 128 and 256 (ratio = 16 shifted left by the code). Exactly one word is produced every ratio clocks.
- R4: Select codes 5, 6 and 7 are ignored. Word spacing, word value and the settled flag continue unchanged. Presenting the code already in use also causes no restart.
- R5: A different legal code is sampled at the next word boundary. The word delivered at that boundary still belongs to the old ratio and arrives at the old spacing. The words after it follow the new spacing.
- R6: `dout_valid` is 0 on the first two words after a reset or a ratio switch and 1 from the third word onward. From the third word onward the value is exact.
- R7: `dout_stb` is high for a single clock, in the same cycle that the new word and flag appear. `dout` and `dout_valid` hold their values between strobes.
- R8: While `rst` is high, all outputs are 0. On reset the ratio is loaded from `osr_sel` if that code is legal, and 256 otherwise. The first word follows one full ratio period after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator bit stream |
| osr_sel | input | 3 | Decimation ratio select (0..4 legal) |
| dout | output | 16 | Scaled and clipped conversion word |
| dout_stb | output | 1 | One-cycle new-word strobe |
| dout_valid | output | 1 | Word is fully settled |

## Verification
A word is due one clock after the edge on which the phase counter reaches ratio minus one. The strobe, the word and the flag all come from that same register stage, so the monitor samples all three together on the falling edge where it sees the strobe. The monitor also counts falling edges between strobes and compares that gap with the ratio in force: the old ratio for the boundary word after a select change, and the new ratio after it. The driver alters the select or the pattern only after the expected-word queue has emptied and one more clock has passed. Any such change therefore lands well before the next boundary, which fixes exactly which word is the first of the new ratio.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int MIN_LOG2  = 4;
    localparam int NUM_RATES = 5;
    localparam int MAX_LOG2  = MIN_LOG2 + NUM_RATES - 1;
    localparam int ORDER     = 3;
    localparam int ACC_W     = 1 + ORDER * MAX_LOG2;
    localparam int OUT_W     = 16;
    localparam int SEL_W     = 3;
    localparam int CNT_W     = MAX_LOG2;
    localparam int SETTLE_WORDS = 3;

    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [OUT_W-1:0] word_t;
    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // boundary event produced by the rate controller
    typedef struct packed {
        logic tick;     // last modulator clock of a decimation period
        logic restart;  // a new ratio is loaded on this boundary
    } frame_ev_t;

    // registered output word
    typedef struct packed {
        word_t data;
        logic  stb;
        logic  settled;
    } word_out_t;

    function automatic logic sel_legal(sel_t sel);
        return int'(sel) < NUM_RATES;
    endfunction

    function automatic int rate_log2(sel_t sel);
        return MIN_LOG2 + int'(sel);
    endfunction

    function automatic cnt_t last_count(sel_t sel);
        return CNT_W'((1 << rate_log2(sel)) - 1);
    endfunction

    // align the raw difference so full scale lands on 2^(OUT_W-1), then clip
    function automatic word_t scale_word(acc_t raw, sel_t sel);
        int   sh;
        acc_t v;
        acc_t lim;
        sh  = ORDER * rate_log2(sel) - (OUT_W - 1);
        if (sh >= 0) v = raw >> sh;
        else         v = raw << (-sh);
        lim = acc_t'((1 << (OUT_W - 1)) - 1);
        if (v > lim) v = lim;
        return v[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/sinc3_rate_ctrl.sv
module sinc3_rate_ctrl
    import sinc3_pkg::*;
#(
    parameter sel_t DEF_SEL = sel_t'(NUM_RATES - 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  sel_t      osr_sel,
    output frame_ev_t ev,
    output sel_t      cur_sel,
    output logic      settled_now
);
    localparam int SEEN_W   = $clog2(SETTLE_WORDS);
    localparam int SEEN_MAX = SETTLE_WORDS - 1;

    cnt_t              phase;
    sel_t              cur;
    logic [SEEN_W-1:0] seen;
    logic              want;

    always_comb begin
        want           = sel_legal(osr_sel) && (osr_sel != cur);
        ev.tick        = (phase == last_count(cur));
        ev.restart     = ev.tick && want;
        settled_now    = (seen == SEEN_W'(SEEN_MAX));
        cur_sel        = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            cur   <= sel_legal(osr_sel) ? osr_sel : DEF_SEL;
            seen  <= '0;
        end else if (ev.tick) begin
            phase <= '0;
            if (want) begin
                cur  <= osr_sel;
                seen <= '0;
            end else if (!settled_now) begin
                seen <= seen + 1'b1;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/sinc3_integrators.sv
module sinc3_integrators
    import sinc3_pkg::*;
#(
    parameter int STAGES = ORDER,
    parameter int W      = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         din,
    output logic [W-1:0] sum_next
);
    logic [STAGES-1:0][W-1:0] acc;
    logic [STAGES-1:0][W-1:0] nxt;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign nxt[s] = acc[s] + {{(W-1){1'b0}}, din};
        end else begin : g_rest
            assign nxt[s] = acc[s] + nxt[s-1];
        end

        always_ff @(posedge clk) begin
            if (rst || clr) acc[s] <= '0;
            else            acc[s] <= nxt[s];
        end
    end

    assign sum_next = nxt[STAGES-1];

endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs
    import sinc3_pkg::*;
#(
    parameter int STAGES = ORDER,
    parameter int W      = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] sample,
    output logic [W-1:0] diff
);
    logic [STAGES-1:0][W-1:0] dly;
    logic [STAGES-1:0][W-1:0] d;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign d[s] = sample - dly[s];
            always_ff @(posedge clk) begin
                if (rst)                dly[s] <= '0;
                else if (tick && clr)   dly[s] <= '0;
                else if (tick)          dly[s] <= sample;
            end
        end else begin : g_rest
            assign d[s] = d[s-1] - dly[s];
            always_ff @(posedge clk) begin
                if (rst)                dly[s] <= '0;
                else if (tick && clr)   dly[s] <= '0;
                else if (tick)          dly[s] <= d[s-1];
            end
        end
    end

    assign diff = d[STAGES-1];

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int   DW      = OUT_W,
    parameter int   SW      = SEL_W,
    parameter sel_t DEF_SEL = sel_t'(NUM_RATES - 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mod_bit,
    input  logic [SW-1:0] osr_sel,
    output logic [DW-1:0] dout,
    output logic          dout_stb,
    output logic          dout_valid
);
    frame_ev_t ev;
    sel_t      cur_sel;
    logic      settled_now;
    acc_t      sum_next;
    acc_t      diff;
    word_out_t outq;

    sinc3_rate_ctrl #(.DEF_SEL(DEF_SEL)) i_rate (
        .clk         (clk),
        .rst         (rst),
        .osr_sel     (sel_t'(osr_sel)),
        .ev          (ev),
        .cur_sel     (cur_sel),
        .settled_now (settled_now)
    );

    sinc3_integrators #(.STAGES(ORDER), .W(ACC_W)) i_integ (
        .clk      (clk),
        .rst      (rst),
        .clr      (ev.restart),
        .din      (mod_bit),
        .sum_next (sum_next)
    );

    sinc3_combs #(.STAGES(ORDER), .W(ACC_W)) i_comb (
        .clk    (clk),
        .rst    (rst),
        .tick   (ev.tick),
        .clr    (ev.restart),
        .sample (sum_next),
        .diff   (diff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            outq <= '0;
        end else begin
            outq.stb <= ev.tick;
            if (ev.tick) begin
                outq.data    <= scale_word(diff, cur_sel);
                outq.settled <= settled_now;
            end
        end
    end

    assign dout       = DW'(outq.data);
    assign dout_stb   = outq.stb;
    assign dout_valid = outq.settled;

endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk
    import sinc3_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mod_bit,
    input logic [SEL_W-1:0] osr_sel,
    input logic [OUT_W-1:0] dout,
    input logic             dout_stb,
    input logic             dout_valid
);
    localparam int GAP_W   = MAX_LOG2 + 1;
    localparam int MIN_GAP = 1 << MIN_LOG2;
    localparam int MAX_GAP = 1 << MAX_LOG2;

    logic [GAP_W-1:0] gap;
    logic             had_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            had_stb <= 1'b0;
        end else if (dout_stb) begin
            gap     <= GAP_W'(1);
            had_stb <= 1'b1;
        end else if (gap != {GAP_W{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        dout_stb |=> !dout_stb);

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !dout_stb |-> ($stable(dout) && $stable(dout_valid)));

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_valid) |-> dout_stb);

    assert_gap_min_R3: assert property (@(posedge clk) disable iff (rst)
        (dout_stb && had_stb) |-> (int'(gap) >= MIN_GAP));

    assert_gap_max_R3: assert property (@(posedge clk) disable iff (rst)
        (dout_stb && had_stb) |-> (int'(gap) <= MAX_GAP));

    assert_word_clip_R2: assert property (@(posedge clk) disable iff (rst)
        dout_stb |-> !dout[OUT_W-1]);

    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dout_stb && !dout_valid));

endmodule

bind sinc3_decimator sinc3_decimator_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .mod_bit    (mod_bit),
    .osr_sel    (osr_sel),
    .dout       (dout),
    .dout_stb   (dout_stb),
    .dout_valid (dout_valid)
);

// File: tb/test_sinc3_decimator.sv
module test_sinc3_decimator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_bit = 1'b0;
    logic [2:0]  osr_sel = 3'd4;
    logic [15:0] dout;
    logic        dout_stb;
    logic        dout_valid;

    always #5 clk = ~clk;

    sinc3_decimator i_sinc3_decimator (
        .clk        (clk),
        .rst        (rst),
        .mod_bit    (mod_bit),
        .osr_sel    (osr_sel),
        .dout       (dout),
        .dout_stb   (dout_stb),
        .dout_valid (dout_valid)
    );

    typedef struct {
        bit    chk_val;
        bit    exp_valid;
        int    exp_val;
        int    exp_gap;
        string req;
    } item_t;

    item_t       exp_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] pat_bits = 16'hFFFF;
    int          pat_len  = 1;

    task automatic check(string req, string what, int act, int expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(bit cv, bit vld, int val, int gap, string req);
        item_t it;
        it.chk_val = cv; it.exp_valid = vld; it.exp_val = val;
        it.exp_gap = gap; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // pattern driver
    initial begin
        int idx;
        idx = 0;
        forever begin
            @(negedge clk);
            mod_bit = pat_bits[idx % pat_len];
            idx++;
        end
    end

    // monitor: pops one expected item per strobe
    initial begin
        int cyc;
        int last;
        cyc = 0;
        last = -1;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                last = -1;
            end else if (dout_stb) begin
                if (exp_q.size() > 0) begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(it.req, "valid flag", int'(dout_valid), int'(it.exp_valid));
                    if (it.chk_val)
                        check(it.req, "word value", int'(dout), it.exp_val);
                    if (it.exp_gap != 0 && last >= 0)
                        check("R3", "strobe spacing", cyc - last, it.exp_gap);
                end
                last = cyc;
            end
        end
    end

    task automatic do_reset(logic [2:0] sel, logic [15:0] bits, int len,
                            int osr, int val, string req);
        drain();
        rst = 1'b1;
        osr_sel = sel;
        pat_bits = bits;
        pat_len = len;
        repeat (3) @(negedge clk);
        check("R8", "dout in reset", int'(dout), 0);
        check("R8", "strobe in reset", int'(dout_stb), 0);
        check("R8", "valid in reset", int'(dout_valid), 0);
        push(1'b0, 1'b0, 0, 0, "R6");
        push(1'b0, 1'b0, 0, osr, "R6");
        for (int k = 0; k < 3; k++) push(1'b1, 1'b1, val, osr, req);
        rst = 1'b0;
        // first word one ratio period after release (R8)
        repeat (osr) @(negedge clk);
        check("R8", "first strobe timing", int'(dout_stb), 1);
    endtask

    task automatic do_change(logic [2:0] sel, logic [15:0] bits, int len,
                             int old_osr, int new_osr, int val, string req);
        drain();
        osr_sel = sel;
        pat_bits = bits;
        pat_len = len;
        push(1'b0, 1'b1, 0, old_osr, "R5");
        push(1'b0, 1'b0, 0, new_osr, "R6");
        push(1'b0, 1'b0, 0, new_osr, "R6");
        for (int k = 0; k < 3; k++) push(1'b1, 1'b1, val, new_osr, req);
    endtask

    initial begin
        do_reset(3'd4, 16'hFFFF, 1, 256, 32767, "R2");
        do_change(3'd0, 16'h0001, 2, 256, 16, 16384, "R1");
        do_change(3'd2, 16'h0001, 4, 16, 64, 8192, "R1");
        // illegal code ignored (R4)
        drain();
        osr_sel = 3'd7;
        for (int k = 0; k < 3; k++) push(1'b1, 1'b1, 8192, 64, "R4");
        drain();
        osr_sel = 3'd5;
        for (int k = 0; k < 2; k++) push(1'b1, 1'b1, 8192, 64, "R4");
        drain();
        osr_sel = 3'd2;   // same code again: no restart (R4)
        for (int k = 0; k < 2; k++) push(1'b1, 1'b1, 8192, 64, "R4");
        do_reset(3'd1, 16'h0000, 1, 32, 0, "R1");
        do_change(3'd3, 16'hFFFF, 1, 32, 128, 32767, "R2");
        do_change(3'd0, 16'h0001, 16, 128, 16, 2048, "R1");
        do_change(3'd4, 16'h0007, 4, 16, 256, 24576, "R1");
        do_change(3'd1, 16'hFFFF, 1, 256, 32, 32767, "R2");
        drain();
        // strobe is a single cycle and word holds (R7)
        while (!dout_stb) @(negedge clk);
        @(negedge clk);
        check("R7", "strobe width", int'(dout_stb), 0);
        check("R7", "word held", int'(dout), 32767);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule